// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block holds the protection half of a serial flash status register and the write-protect logic that guards it. A host talks to it over an SPI mode-0 byte stream (chip select, serial clock, data in, data out). Only two commands are understood: a status write, which loads the protection fields, and an information read, which streams a one-byte snapshot of the protection state. Every other opcode is ignored. The block also answers program and erase requests from the surrounding flash controller, permitting or refusing each one based on the block-protect range, the OTP mode flag and the one-time OTP lock.

The protection fields are non-volatile. They are modelled as flops that have no reset and keep their value while `rst_n` is low; their erased content is all zeros. The SPI inputs are brought into the `clk` domain through a synchroniser, so the serial clock must run several times slower than `clk`.

Top module: `flash_prot_unit`

## Requirements
- R1: `status_o` bit 7 is the protect bit (the OTP lock while `otp_mode` is 1), bit 6 is the pin-disable bit, bits 5..2 are block-protect field BP[3:0], bit 1 mirrors `wel` and bit 0 mirrors `busy`; the erased value of bits 7..2 is 0, and a reset does not change them.
- R2: A status write (opcode 0x01, then one data byte) with `wel`=1 and `busy`=0, ending with chip select rising on a byte boundary, copies data bits 7..2 into `status_o` bits 7..2 and pulses `wel_clr` high for exactly one clock.
- R3: A status write is discarded, with no register change and no `wel_clr` pulse, when `wel` is 0, when `busy` is 1, when chip select rises off a byte boundary, or when more than one data byte follows the opcode.
- R4: The block is hardware-protected when the protect bit is 1, `wp_n` is 0 and the pin-disable bit is 0; while protected, a status write outside OTP mode is discarded as a whole.
- R5: With the pin-disable bit at 1, `wp_n` has no effect and status writes are accepted whatever its level.
- R6: The information read (opcode 0x2B) shifts out, MSB first and changing after each falling serial-clock edge, the byte {OTP lock, hardware-protected, pin-disable, `otp_mode`, 4'b0000}; the byte repeats while chip select stays low, and `spi_miso` is 0 outside a read.
- R7: The information read gives valid data while `busy` is 1.
- R8: In OTP mode an accepted status write ignores its data byte, sets the OTP lock and leaves bits 6..2 unchanged.
- R9: Once set, the OTP lock stays 1 through further status writes, leaving OTP mode and reset.
- R10: A request to the OTP sector (`pe_otp`=1) is permitted only when `otp_mode` is 1 and the OTP lock is 0.
- R11: A request to a normal sector is refused in OTP mode and when the sector lies in the protected top range: BP=0 protects nothing, BP=k protects the top 2^(k-1) sectors, and a range larger than the array protects all of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset for the volatile state |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | High while the OTP sector is mapped in |
| busy | input | 1 | Program, erase or status write in progress |
| wel | input | 1 | Write-enable latch from the command layer |
| wel_clr | output | 1 | One-clock request to clear the write-enable latch |
| status_o | output | 8 | Current status register value |
| pe_req | input | 1 | Program or erase request valid |
| pe_otp | input | 1 | Request targets the OTP sector |
| pe_sector | input | SECT_W | Sector index of a normal-sector request |
| pe_allow | output | 1 | Request is permitted |

## Verification
The hardest state to reach is a locked OTP sector after a reset and a trip out of OTP mode. The lock can be set only once per run and nothing clears it, so the bench orders its scenarios so that everything that needs the lock at 0 comes first. Only the last task sets it, through a real status-write frame in OTP mode. That task then repeats the write, applies reset, and leaves and re-enters OTP mode, checking the lock through `status_o`, the information read and OTP-sector requests. The hardware-protect matrix is reached the same way: with `wp_n` high the bench writes each protect-bit value, then lowers `wp_n`.

// File: rtl/flash_prot_pkg.sv
// Package: shared opcodes, decoder state and the non-volatile field layout.
package flash_prot_pkg;

    localparam logic [7:0] OP_WRITE_STATUS = 8'h01;
    localparam logic [7:0] OP_READ_INFO    = 8'h2B;

    // Command decoder progress through one chip-select frame.
    typedef enum logic [2:0] {
        DEC_OPCODE,     // next byte is the opcode
        DEC_WAIT_DATA,  // status write, data byte pending
        DEC_HAVE_DATA,  // status write, exactly one data byte seen
        DEC_READ,       // information byte streaming out
        DEC_SKIP        // frame ignored until chip select rises
    } dec_state_t;

    // Non-volatile protection fields, in status-register bit order 7..2.
    typedef struct packed {
        logic       protect;
        logic       pin_dis;
        logic [3:0] bp;
    } nv_status_t;

endpackage

// File: rtl/spi_frontend.sv
// spi_frontend
//   Brings the SPI pins into the clk domain, assembles mode-0 bytes from
//   rising serial-clock edges and shifts a byte out on falling edges.
//   Assumes the serial clock half period spans several clk cycles so the
//   synchroniser sees every level.
module spi_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       rd_active,
    input  logic [7:0] tx_byte,
    output logic       frame_start,
    output logic       frame_end,
    output logic       frame_aligned,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       miso
);

    localparam int BIT_W = 3;

    logic [SYNC_STAGES:0] cs_p;
    logic [SYNC_STAGES:0] sck_p;
    logic [SYNC_STAGES:0] mosi_p;

    assign cs_p[0]   = cs_n;
    assign sck_p[0]  = sck;
    assign mosi_p[0] = mosi;

    // One flop per synchroniser stage for each of the three pins.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        // Purpose: move each pin one stage closer to the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cs_p[s+1]   <= 1'b1;
                sck_p[s+1]  <= 1'b0;
                mosi_p[s+1] <= 1'b0;
            end else begin
                cs_p[s+1]   <= cs_p[s];
                sck_p[s+1]  <= sck_p[s];
                mosi_p[s+1] <= mosi_p[s];
            end
        end
    end

    logic cs_s, sck_s, mosi_s;
    logic cs_d, sck_d;
    logic sel, sck_rise, sck_fall;

    assign cs_s   = cs_p[SYNC_STAGES];
    assign sck_s  = sck_p[SYNC_STAGES];
    assign mosi_s = mosi_p[SYNC_STAGES];

    // Purpose: keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign sel         = ~cs_s;
    assign sck_rise    = sel & sck_s & ~sck_d;
    assign sck_fall    = sel & ~sck_s & sck_d;
    assign frame_start = cs_d & ~cs_s;
    assign frame_end   = ~cs_d & cs_s;

    logic [BIT_W-1:0] bit_cnt;
    logic [6:0]       rx_sh;
    logic             byte_valid_q;
    logic [7:0]       byte_q;

    // Purpose: shift in data on rising edges and flag each complete byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            rx_sh        <= '0;
            byte_valid_q <= 1'b0;
            byte_q       <= '0;
        end else begin
            byte_valid_q <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    byte_valid_q <= 1'b1;
                    byte_q       <= {rx_sh, mosi_s};
                end
            end
        end
    end

    assign frame_aligned = (bit_cnt == '0);
    assign byte_valid    = byte_valid_q;
    assign byte_data     = byte_q;

    logic [BIT_W-1:0] tx_ptr;
    logic             miso_q;

    // Purpose: drive the read byte MSB first, wrapping so it repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ptr <= 3'd7;
            miso_q <= 1'b0;
        end else if (!sel || !rd_active) begin
            tx_ptr <= 3'd7;
            miso_q <= 1'b0;
        end else if (sck_fall) begin
            miso_q <= tx_byte[tx_ptr];
            tx_ptr <= tx_ptr - 3'd1;
        end
    end

    assign miso = miso_q;

endmodule

// File: rtl/cmd_decoder.sv
// cmd_decoder
//   Follows the bytes of one chip-select frame. Recognises the status write
//   and the information read; every other opcode makes the frame inert.
//   A status write is requested only when exactly one data byte arrived and
//   chip select rose on a byte boundary.
module cmd_decoder
    import flash_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       frame_end,
    input  logic       frame_aligned,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       wr_req,
    output logic [5:0] wr_fields,
    output logic       rd_active
);

    dec_state_t st;
    logic       wr_req_q;
    logic [5:0] fields_q;

    // Purpose: step the frame state on each byte and commit at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= DEC_SKIP;
            wr_req_q <= 1'b0;
            fields_q <= '0;
        end else begin
            wr_req_q <= 1'b0;
            if (frame_start) begin
                st <= DEC_OPCODE;
            end else if (frame_end) begin
                wr_req_q <= (st == DEC_HAVE_DATA) && frame_aligned;
                st       <= DEC_SKIP;
            end else if (byte_valid) begin
                unique case (st)
                    DEC_OPCODE: begin
                        if (byte_data == OP_WRITE_STATUS)
                            st <= DEC_WAIT_DATA;
                        else if (byte_data == OP_READ_INFO)
                            st <= DEC_READ;
                        else
                            st <= DEC_SKIP;
                    end
                    DEC_WAIT_DATA: begin
                        fields_q <= byte_data[7:2];
                        st       <= DEC_HAVE_DATA;
                    end
                    DEC_HAVE_DATA: st <= DEC_SKIP;
                    DEC_READ:      st <= DEC_READ;
                    DEC_SKIP:      st <= DEC_SKIP;
                    default:       st <= DEC_SKIP;
                endcase
            end
        end
    end

    assign wr_req    = wr_req_q;
    assign wr_fields = fields_q;
    assign rd_active = (st == DEC_READ);

endmodule

// File: rtl/prot_regs.sv
// prot_regs
//   Holds the non-volatile protection fields and the OTP lock, and applies
//   the write rules. The non-volatile flops have no reset: they keep their
//   value across rst_n and are assumed to power up erased (all zeros).
//   Only the write-enable clear strobe is volatile.
module prot_regs
    import flash_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic [5:0] wr_fields,
    input  logic       wel,
    input  logic       busy,
    input  logic       wp_n,
    input  logic       otp_mode,
    output nv_status_t nv,
    output logic       otp_lock,
    output logic       hw_prot,
    output logic       wel_clr
);

    nv_status_t nv_q;
    logic       lock_q;
    logic       accept;
    logic       wel_clr_q;

    assign hw_prot = nv_q.protect & ~wp_n & ~nv_q.pin_dis;
    assign accept  = wr_req & wel & ~busy & (otp_mode | ~hw_prot);

    // Purpose: update the non-volatile cells on an accepted status write.
    always_ff @(posedge clk) begin
        if (accept) begin
            if (otp_mode)
                lock_q <= 1'b1;
            else
                nv_q <= nv_status_t'(wr_fields);
        end
    end

    // Purpose: ask the command layer to clear write-enable after a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_clr_q <= 1'b0;
        else
            wel_clr_q <= accept;
    end

    assign nv       = nv_q;
    assign otp_lock = lock_q;
    assign wel_clr  = wel_clr_q;

endmodule

// File: rtl/pe_guard.sv
// pe_guard
//   Decides whether a program or erase request may proceed. Normal sectors
//   are guarded by a top-of-array range chosen by the block-protect field;
//   the OTP sector is guarded by OTP mode and the one-time lock.
module pe_guard #(
    parameter int SECT_W = 8
) (
    input  logic              pe_req,
    input  logic              pe_otp,
    input  logic [SECT_W-1:0] pe_sector,
    input  logic [3:0]        bp,
    input  logic              otp_mode,
    input  logic              otp_lock,
    output logic              pe_allow
);

    logic [SECT_W-1:0] from_top;
    logic [3:0]        shamt;
    logic              in_range;
    logic              ok_otp, ok_norm;

    // Purpose: test the sector against the top 2^(bp-1) protected sectors.
    always_comb begin
        from_top = ~pe_sector;
        shamt    = bp - 4'd1;
        in_range = (bp != 4'd0) && ((from_top >> shamt) == '0);
    end

    assign ok_otp   = otp_mode & ~otp_lock;
    assign ok_norm  = ~otp_mode & ~in_range;
    assign pe_allow = pe_req & (pe_otp ? ok_otp : ok_norm);

endmodule

// File: rtl/flash_prot_unit.sv
// flash_prot_unit
//   Top of the status-register protection unit. Wires the SPI front end,
//   the command decoder, the protection registers and the request guard,
//   and forms the status and information bytes.
module flash_prot_unit
    import flash_prot_pkg::*;
#(
    parameter int SECT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wp_n,
    input  logic              otp_mode,
    input  logic              busy,
    input  logic              wel,
    output logic              wel_clr,
    output logic [7:0]        status_o,
    input  logic              pe_req,
    input  logic              pe_otp,
    input  logic [SECT_W-1:0] pe_sector,
    output logic              pe_allow
);

    logic       frame_start, frame_end, frame_aligned;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       wr_req, rd_active;
    logic [5:0] wr_fields;
    nv_status_t nv;
    logic       otp_lock, hw_prot;
    logic [7:0] info_byte;

    spi_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_spi (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (spi_cs_n),
        .sck           (spi_sck),
        .mosi          (spi_mosi),
        .rd_active     (rd_active),
        .tx_byte       (info_byte),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .frame_aligned (frame_aligned),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .miso          (spi_miso)
    );

    cmd_decoder u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .frame_aligned (frame_aligned),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .wr_req        (wr_req),
        .wr_fields     (wr_fields),
        .rd_active     (rd_active)
    );

    prot_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_fields (wr_fields),
        .wel       (wel),
        .busy      (busy),
        .wp_n      (wp_n),
        .otp_mode  (otp_mode),
        .nv        (nv),
        .otp_lock  (otp_lock),
        .hw_prot   (hw_prot),
        .wel_clr   (wel_clr)
    );

    pe_guard #(.SECT_W(SECT_W)) u_guard (
        .pe_req    (pe_req),
        .pe_otp    (pe_otp),
        .pe_sector (pe_sector),
        .bp        (nv.bp),
        .otp_mode  (otp_mode),
        .otp_lock  (otp_lock),
        .pe_allow  (pe_allow)
    );

    // Information byte: lock, hardware-protected, pin-disable, OTP mode.
    assign info_byte = {otp_lock, hw_prot, nv.pin_dis, otp_mode, 4'b0000};

    // Status byte: bit 7 shows the OTP lock while in OTP mode.
    assign status_o = {(otp_mode ? otp_lock : nv.protect), nv.pin_dis,
                       nv.bp, wel, busy};

endmodule

// File: rtl/flash_prot_checker.sv
// flash_prot_checker
//   Temporal properties of the protection unit, attached by bind.
module flash_prot_checker #(
    parameter int SECT_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       otp_mode,
    input logic       pe_otp,
    input logic       pe_allow,
    input logic       wel_clr,
    input logic [7:0] status_o,
    input logic [7:0] info
);

    // R2: the clear strobe lasts a single clock
    a_r2_wel_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);

    // R2: protection fields move only together with an accepted write
    a_r2_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o[6:2]) |-> wel_clr);

    // R4: while hardware-protected, the fields cannot move
    a_r4_hwp_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        info[6] |=> $stable(status_o[6:2]));

    // R9: the OTP lock never returns to zero
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        info[7] |=> info[7]);

    // R10: an OTP-sector grant needs OTP mode and an open lock
    a_r10_otp_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_allow && pe_otp) |-> (otp_mode && !info[7]));

    // R11: no normal-sector grant while in OTP mode
    a_r11_no_normal_in_otp: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_allow && !pe_otp) |-> !otp_mode);

endmodule

bind flash_prot_unit flash_prot_checker #(.SECT_W(SECT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .otp_mode (otp_mode),
    .pe_otp   (pe_otp),
    .pe_allow (pe_allow),
    .wel_clr  (wel_clr),
    .status_o (status_o),
    .info     (info_byte)
);

// File: tb/tb_flash_prot_unit.sv
module tb_flash_prot_unit;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int SECT_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic              spi_miso;
    logic              wp_n = 1'b1, otp_mode = 1'b0, busy = 1'b0, wel = 1'b0;
    logic              wel_clr;
    logic [7:0]        status_o;
    logic              pe_req = 1'b0, pe_otp = 1'b0;
    logic [SECT_W-1:0] pe_sector = '0;
    logic              pe_allow;

    int checks = 0;
    int errors = 0;
    int clr_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prot_unit #(.SECT_W(SECT_W)) dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wp_n(wp_n),
        .otp_mode(otp_mode), .busy(busy), .wel(wel), .wel_clr(wel_clr),
        .status_o(status_o), .pe_req(pe_req), .pe_otp(pe_otp),
        .pe_sector(pe_sector), .pe_allow(pe_allow)
    );

    // Count clear strobes away from the active edge.
    always @(negedge clk) if (rst_n && wel_clr) clr_count++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        spi_sck  = 1'b0;
        spi_cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic spi_bit(input logic b);
        spi_mosi = b;
        wait_clk(HALF);
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    endtask

    task automatic spi_read(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF);
            b[i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic wrsr(input logic [7:0] d);
        cs_low();
        spi_byte(8'h01);
        spi_byte(d);
        cs_high();
    endtask

    task automatic read_info(output logic [7:0] b);
        cs_low();
        spi_byte(8'h2B);
        spi_read(b);
        cs_high();
    endtask

    task automatic probe(input logic otp, input int sector, output logic ok);
        pe_req = 1'b1;
        pe_otp = otp;
        pe_sector = SECT_W'(sector);
        wait_clk(1);
        ok = pe_allow;
        pe_req = 1'b0;
    endtask

    task automatic t_reset_state();
        logic ok;
        check(status_o == 8'h00, "R1 reset status", status_o, 8'h00);
        check(spi_miso == 1'b0, "R6 idle miso", spi_miso, 0);
        probe(1'b0, 255, ok);
        check(ok == 1'b1, "R11 bp0 top sector", ok, 1);
    endtask

    task automatic t_basic_write();
        int c0;
        c0 = clr_count;
        wel = 1'b1;
        wrsr(8'h14);
        check(status_o[7:2] == 6'b000101, "R2 write fields", status_o[7:2], 6'b000101);
        check(status_o[1:0] == 2'b10, "R1 wel/busy mirror", status_o[1:0], 2'b10);
        check(clr_count == c0 + 1, "R2 one clear strobe", clr_count - c0, 1);
        wel = 1'b0;
    endtask

    task automatic t_rejects();
        int c0;
        c0 = clr_count;
        wrsr(8'h00);
        check(status_o[7:2] == 6'b000101, "R3 no wel", status_o[7:2], 6'b000101);
        wel = 1'b1; busy = 1'b1;
        wrsr(8'h00);
        busy = 1'b0;
        check(status_o[7:2] == 6'b000101, "R3 busy", status_o[7:2], 6'b000101);
        cs_low(); spi_byte(8'h01);
        for (int i = 0; i < 7; i++) spi_bit(1'b0);
        cs_high();
        check(status_o[7:2] == 6'b000101, "R3 seven bits", status_o[7:2], 6'b000101);
        cs_low(); spi_byte(8'h01); spi_byte(8'h00); spi_byte(8'h00); cs_high();
        check(status_o[7:2] == 6'b000101, "R3 two bytes", status_o[7:2], 6'b000101);
        check(clr_count == c0, "R3 no clear strobe", clr_count - c0, 0);
        wel = 1'b0;
    endtask

    task automatic t_reset_keeps();
        do_reset();
        check(status_o[7:2] == 6'b000101, "R1 fields survive reset", status_o[7:2], 6'b000101);
    endtask

    task automatic t_hwp_matrix();
        logic [7:0] inf;
        logic       exp_hwp;
        wel = 1'b1;
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 2; w++) begin
                wp_n = 1'b1;
                wrsr({s[0], 7'b0});
                wp_n = w[0];
                exp_hwp = s[0] & ~w[0];
                read_info(inf);
                check(inf[6] == exp_hwp, "R4 hwp flag", inf[6], exp_hwp);
                wrsr(8'h04);
                check(status_o[5:2] == (exp_hwp ? 4'd0 : 4'd1), "R4 write gated",
                      status_o[5:2], exp_hwp ? 0 : 1);
                wp_n = 1'b1;
                wrsr(8'h00);
                check(status_o[7:2] == 6'd0, "R4 restore", status_o[7:2], 0);
            end
        end
        wrsr(8'hC0);
        wp_n = 1'b0;
        read_info(inf);
        check(inf[6] == 1'b0, "R5 disable masks wp", inf[6], 0);
        wrsr(8'h04);
        check(status_o[7:2] == 6'b000001, "R5 write with wp low", status_o[7:2], 6'b000001);
        wp_n = 1'b1;
        wrsr(8'h00);
        wel = 1'b0;
    endtask

    task automatic t_info_read();
        logic [7:0] b;
        wel = 1'b1;
        wrsr(8'h40);
        wel = 1'b0;
        busy = 1'b1;
        cs_low();
        spi_byte(8'h2B);
        for (int k = 0; k < 3; k++) begin
            spi_read(b);
            check(b == 8'h20, "R7 repeated read while busy", b, 8'h20);
        end
        cs_high();
        busy = 1'b0;
        check(spi_miso == 1'b0, "R6 miso idle after read", spi_miso, 0);
        otp_mode = 1'b1;
        read_info(b);
        check(b == 8'h30, "R6 info layout", b, 8'h30);
        otp_mode = 1'b0;
        wel = 1'b1;
        wrsr(8'h00);
        wel = 1'b0;
    endtask

    task automatic t_bp_range();
        logic ok;
        wel = 1'b1;
        wrsr(8'h04);
        probe(1'b0, 255, ok); check(ok == 1'b0, "R11 bp1 top", ok, 0);
        probe(1'b0, 254, ok); check(ok == 1'b1, "R11 bp1 below", ok, 1);
        wrsr(8'h0C);
        probe(1'b0, 252, ok); check(ok == 1'b0, "R11 bp3 edge", ok, 0);
        probe(1'b0, 251, ok); check(ok == 1'b1, "R11 bp3 below", ok, 1);
        wrsr(8'h24);
        probe(1'b0, 0, ok);   check(ok == 1'b0, "R11 bp9 all", ok, 0);
        wrsr(8'h3C);
        probe(1'b0, 0, ok);   check(ok == 1'b0, "R11 bp15 all", ok, 0);
        wrsr(8'h00);
        probe(1'b0, 0, ok);   check(ok == 1'b1, "R11 bp0 none", ok, 1);
        otp_mode = 1'b1;
        probe(1'b0, 0, ok);   check(ok == 1'b0, "R11 normal in otp mode", ok, 0);
        otp_mode = 1'b0;
        wel = 1'b0;
    endtask

    task automatic t_otp_lock();
        logic       ok;
        logic [7:0] inf;
        int         c0;
        wel = 1'b1;
        wrsr(8'h3C);
        otp_mode = 1'b1;
        probe(1'b1, 0, ok);
        check(ok == 1'b1, "R10 otp open", ok, 1);
        c0 = clr_count;
        wrsr(8'h00);
        check(status_o[7] == 1'b1, "R8 lock set", status_o[7], 1);
        check(status_o[6:2] == 5'b01111, "R8 data ignored", status_o[6:2], 5'b01111);
        check(clr_count == c0 + 1, "R8 clear strobe", clr_count - c0, 1);
        probe(1'b1, 0, ok);
        check(ok == 1'b0, "R10 otp locked", ok, 0);
        read_info(inf);
        check(inf[7] == 1'b1, "R9 info lock", inf[7], 1);
        wrsr(8'h00);
        check(status_o[7] == 1'b1, "R9 rewrite keeps lock", status_o[7], 1);
        do_reset();
        check(status_o[7] == 1'b1, "R9 lock after reset", status_o[7], 1);
        otp_mode = 1'b0;
        wait_clk(1);
        check(status_o[7] == 1'b0, "R1 bit7 shows protect", status_o[7], 0);
        wrsr(8'h00);
        check(status_o[7:2] == 6'd0, "R2 normal write after lock", status_o[7:2], 0);
        otp_mode = 1'b1;
        wait_clk(1);
        check(status_o[7] == 1'b1, "R9 lock after leaving otp", status_o[7], 1);
        probe(1'b1, 0, ok);
        check(ok == 1'b0, "R10 still refused", ok, 0);
        otp_mode = 1'b0;
        wel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_basic_write();
        t_rejects();
        t_reset_keeps();
        t_hwp_matrix();
        t_info_read();
        t_bp_range();
        t_otp_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule